// File: doc/BRIEF.md
# Integer Execution Unit with Immediate Operands

This block is the arithmetic and logic stage of a small 32-bit load-store datapath. It receives the two source register values already read from the register file, together with the raw 32-bit instruction word. From that word it decodes the operation itself, using the opcode, the three-bit function field and the alternate bit of the seven-bit function field. It also forms its own immediates: the signed 12-bit one and the 20-bit upper one. A separate select input chooses whether the second operand is the register value or the sign-extended 12-bit immediate.

The unit is purely combinational. A result appears in the same cycle as its inputs, and the surrounding pipeline registers it. The block supports addition, subtraction, the three bitwise operations, left shift, signed less-than comparison and upper-immediate loading. Any instruction word it does not recognise yields a zero result.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0110011 (register class) or 0010011 (immediate class) and function field bits 14:12 = 000, the result is first operand plus second operand, wrapped modulo 2^32. No overflow indication is given.
- R2: With opcode 0110011, bits 14:12 = 000 and instruction bit 30 set, the result is first operand minus second operand, wrapped modulo 2^32.
- R3: With opcode 0010011 and bits 14:12 = 000, instruction bit 30 has no effect. The operation stays an addition, and the bit counts only as part of the immediate value.
- R4: With either class opcode, bits 14:12 = 111 give bitwise AND, 110 give bitwise OR and 100 give bitwise XOR of the two operands.
- R5: With either class opcode and bits 14:12 = 001, the first operand is shifted left by the low 5 bits of the second operand, and zeros fill the vacated positions.
- R6: With either class opcode and bits 14:12 = 010, the result is exactly 1 when the first operand is less than the second, both read as two's-complement signed values. Otherwise the result is 0.
- R7: When `useImm` is 1, the second operand is instruction bits 31:20 sign-extended to 32 bits. This covers the range -2048 to +2047.
- R8: With opcode 0110111, the result is instruction bits 31:12 placed in result bits 31:12 with zeros below, so field 0x12345 gives 0x12345000. Both register operands and `useImm` are ignored.
- R9: Any other opcode, or a class opcode with bits 14:12 equal to 011 or 101, gives a result of 0.
- R10: When `useImm` is 0, the second operand is `rs2Val`, whatever the opcode class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs1Val | input | 32 | First source operand |
| rs2Val | input | 32 | Second source register operand |
| instrWord | input | 32 | Full instruction word supplying opcode, function fields and immediates |
| useImm | input | 1 | 1 selects the sign-extended 12-bit immediate as second operand |
| result | output | 32 | Computed result |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 12-bit short immediate and a 20-bit upper immediate. These fix the instruction field positions, so every decode path is reachable. A full sweep then crosses four opcode classes, all eight function codes, both states of bit 30 and both operand selects. It applies these to operand pairs drawn from the sign boundaries, all-ones, zero and pseudo-random words. Directed cases cover the extreme immediates, wraparound in both directions, shift amounts above 31 and the upper-immediate example.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_UPPER = 7'b0110111;

  localparam logic [2:0] F3_ADD = 3'b000;
  localparam logic [2:0] F3_SHL = 3'b001;
  localparam logic [2:0] F3_LES = 3'b010;
  localparam logic [2:0] F3_XOR = 3'b100;
  localparam logic [2:0] F3_OR  = 3'b110;
  localparam logic [2:0] F3_AND = 3'b111;

  // Strobes passed from the decoder to the datapath
  typedef struct packed {
    logic selAdd;
    logic selSub;
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selShl;
    logic selLess;
    logic selUpper;
    logic takeImm;
  } strobes_t;

endpackage

// File: rtl/iexu_ctrl.sv
module iexu_ctrl
  import iexu_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic       altBit,
  input  logic       useImm,
  output strobes_t   strb
);

  logic isClass;
  assign isClass = (opcode == OPC_REG) || (opcode == OPC_IMM);

  always_comb begin
    strb         = '0;
    strb.takeImm = useImm;
    if (opcode == OPC_UPPER) begin
      strb.selUpper = 1'b1;
    end else if (isClass) begin
      case (funct3)
        F3_ADD: begin
          if (opcode == OPC_REG && altBit) strb.selSub = 1'b1;
          else                             strb.selAdd = 1'b1;
        end
        F3_SHL:  strb.selShl  = 1'b1;
        F3_LES:  strb.selLess = 1'b1;
        F3_XOR:  strb.selXor  = 1'b1;
        F3_OR:   strb.selOr   = 1'b1;
        F3_AND:  strb.selAnd  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    // R9
    strobe_onehot_chk: assert ($onehot0({strb.selAdd, strb.selSub, strb.selAnd, strb.selOr,
                                         strb.selXor, strb.selShl, strb.selLess, strb.selUpper}));
    // R3
    if (opcode == OPC_IMM) begin
      imm_no_sub_chk: assert (!strb.selSub);
    end
    // R8
    if (opcode == OPC_UPPER) begin
      upper_only_chk: assert (strb.selUpper && !strb.selAdd && !strb.selLess);
    end
  end

endmodule

// File: rtl/iexu_dp.sv
module iexu_dp
  import iexu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 12,
  parameter int UIMM_W = 20
) (
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [31:0]     instrWord,
  input  strobes_t        strb,
  output logic [XLEN-1:0] result
);

  localparam int SHW    = $clog2(XLEN);
  localparam int ULOW_W = 32 - UIMM_W;

  logic [XLEN-1:0] immShort;
  logic [XLEN-1:0] immUpper;
  logic [31:0]     upper32;
  logic [XLEN-1:0] operandB;
  logic [XLEN-1:0] addendB;
  logic [XLEN-1:0] sumVal;
  logic [XLEN-1:0] shlVal;
  logic            lessBit;
  logic [SHW-1:0]  shAmt;

  assign immShort = {{(XLEN-IMM_W){instrWord[31]}}, instrWord[31 -: IMM_W]};
  assign upper32  = {instrWord[31 -: UIMM_W], {ULOW_W{1'b0}}};

  generate
    if (XLEN > 32) begin : g_wideUpper
      assign immUpper = {{(XLEN-32){upper32[31]}}, upper32};
    end else begin : g_nativeUpper
      assign immUpper = upper32[XLEN-1:0];
    end
  endgenerate

  assign operandB = strb.takeImm ? immShort : rs2Val;
  assign addendB  = strb.selSub ? ~operandB : operandB;
  assign sumVal   = rs1Val + addendB + {{(XLEN-1){1'b0}}, strb.selSub};
  assign shAmt    = operandB[SHW-1:0];
  assign shlVal   = rs1Val << shAmt;
  assign lessBit  = $signed(rs1Val) < $signed(operandB);

  always_comb begin
    result = '0;
    if (strb.selAdd || strb.selSub) result = result | sumVal;
    if (strb.selAnd)   result = result | (rs1Val & operandB);
    if (strb.selOr)    result = result | (rs1Val | operandB);
    if (strb.selXor)   result = result | (rs1Val ^ operandB);
    if (strb.selShl)   result = result | shlVal;
    if (strb.selLess)  result = result | {{(XLEN-1){1'b0}}, lessBit};
    if (strb.selUpper) result = result | immUpper;
  end

  always_comb begin
    // R6
    if (strb.selLess) begin
      less_range_chk: assert (result[XLEN-1:1] == '0);
    end
    // R8
    if (strb.selUpper) begin
      upper_low_chk: assert (result[ULOW_W-1:0] == '0);
    end
    // R5
    if (strb.selShl) begin
      shl_fill_chk: assert ((result & ((XLEN'(1) << shAmt) - XLEN'(1))) == '0);
    end
    // R9
    if (!(strb.selAdd || strb.selSub || strb.selAnd || strb.selOr || strb.selXor ||
          strb.selShl || strb.selLess || strb.selUpper)) begin
      idle_zero_chk: assert (result == '0);
    end
    // R2
    if (strb.selSub && operandB == '0) begin
      sub_zero_chk: assert (result == rs1Val);
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 12,
  parameter int UIMM_W = 20
) (
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [31:0]     instrWord,
  input  logic            useImm,
  output logic [XLEN-1:0] result
);

  strobes_t strb;

  iexu_ctrl u_ctrl (
    .opcode (instrWord[6:0]),
    .funct3 (instrWord[14:12]),
    .altBit (instrWord[30]),
    .useImm (useImm),
    .strb   (strb)
  );

  iexu_dp #(
    .XLEN   (XLEN),
    .IMM_W  (IMM_W),
    .UIMM_W (UIMM_W)
  ) u_dp (
    .rs1Val    (rs1Val),
    .rs2Val    (rs2Val),
    .instrWord (instrWord),
    .strb      (strb),
    .result    (result)
  );

endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;

  logic        clk = 1'b0;
  logic [31:0] rs1Val = '0;
  logic [31:0] rs2Val = '0;
  logic [31:0] instrWord = '0;
  logic        useImm = 1'b0;
  logic [31:0] result;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  int_exec_unit u0 (
    .rs1Val    (rs1Val),
    .rs2Val    (rs2Val),
    .instrWord (instrWord),
    .useImm    (useImm),
    .result    (result)
  );

  function automatic logic [31:0] mkInstr(input logic [6:0] opc, input logic [2:0] f3,
                                          input logic [11:0] imm12);
    return {imm12, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [31:0] refModel(input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] ins, input logic sel);
    logic [31:0] bOp;
    logic [6:0]  opc;
    opc = ins[6:0];
    bOp = sel ? {{20{ins[31]}}, ins[31:20]} : b;
    if (opc == 7'b0110111) return {ins[31:12], 12'h000};
    if (opc != 7'b0110011 && opc != 7'b0010011) return 32'h0;
    case (ins[14:12])
      3'b000: return (opc == 7'b0110011 && ins[30]) ? a - bOp : a + bOp;
      3'b001: return a << bOp[4:0];
      3'b010: return ($signed(a) < $signed(bOp)) ? 32'd1 : 32'd0;
      3'b100: return a ^ bOp;
      3'b110: return a | bOp;
      3'b111: return a & bOp;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [31:0] ins);
    logic [6:0] opc;
    opc = ins[6:0];
    if (opc == 7'b0110111) return "R8";
    if (opc != 7'b0110011 && opc != 7'b0010011) return "R9";
    case (ins[14:12])
      3'b000: return (opc == 7'b0110011 && ins[30]) ? "R2" : "R1";
      3'b001: return "R5";
      3'b010: return "R6";
      3'b100, 3'b110, 3'b111: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic applyCheck(input string tag, input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] ins, input logic sel,
                            input logic [31:0] expVal);
    @(negedge clk);
    rs1Val    = a;
    rs2Val    = b;
    instrWord = ins;
    useImm    = sel;
    #1;
    checks++;
    if (result !== expVal) begin
      failures++;
      $display("FAIL %s a=%h b=%h ins=%h sel=%0d actual=%h expected=%h",
               tag, a, b, ins, sel, result, expVal);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] opnd [12];
    logic [11:0] imms [8];
    logic [6:0]  opcs [4];
    logic [31:0] lfsr;
    opnd[0] = 32'h0;        opnd[1] = 32'h1;        opnd[2] = 32'hFFFFFFFF;
    opnd[3] = 32'h7FFFFFFF; opnd[4] = 32'h80000000; opnd[5] = 32'h12345678;
    opnd[6] = 32'h0000001F; opnd[7] = 32'h00000021;
    lfsr = 32'hACE1BEEF;
    for (int k = 8; k < 12; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} * 32'd2654435761 + 32'd977;
      opnd[k] = lfsr;
    end
    imms[0] = 12'h000; imms[1] = 12'h7FF; imms[2] = 12'h800; imms[3] = 12'hFFF;
    imms[4] = 12'h001; imms[5] = 12'h0FF; imms[6] = 12'h41F; imms[7] = 12'h5A3;
    opcs[0] = 7'b0110011; opcs[1] = 7'b0010011; opcs[2] = 7'b0110111; opcs[3] = 7'b0000011;

    // Quiescent all-zero inputs: addition of zeros (R1)
    applyCheck("R1", 32'h0, 32'h0, 32'h0000_0033, 1'b0, 32'h0);

    // Directed corners
    applyCheck("R1", 32'hFFFFFFFF, 32'h1, mkInstr(7'b0110011, 3'b000, 12'h000), 1'b0, 32'h0);
    applyCheck("R2", 32'h0, 32'h1, mkInstr(7'b0110011, 3'b000, 12'h400), 1'b0, 32'hFFFFFFFF);
    applyCheck("R2", 32'h80000000, 32'h1, mkInstr(7'b0110011, 3'b000, 12'h400), 1'b0, 32'h7FFFFFFF);
    applyCheck("R3", 32'h10, 32'h5, mkInstr(7'b0010011, 3'b000, 12'h400), 1'b1, 32'h410);
    applyCheck("R7", 32'h0, 32'h0, mkInstr(7'b0010011, 3'b000, 12'h800), 1'b1, 32'hFFFFF800);
    applyCheck("R7", 32'h0, 32'h0, mkInstr(7'b0010011, 3'b000, 12'h7FF), 1'b1, 32'h000007FF);
    applyCheck("R7", 32'hFFFF1234, 32'h0, mkInstr(7'b0010011, 3'b111, 12'hFFF), 1'b1, 32'hFFFF1234);
    applyCheck("R4", 32'hF0F0F0F0, 32'h0FF00FF0, mkInstr(7'b0110011, 3'b100, 12'h000), 1'b0, 32'hFF00FF00);
    applyCheck("R5", 32'h3, 32'h21, mkInstr(7'b0110011, 3'b001, 12'h000), 1'b0, 32'h6);
    applyCheck("R5", 32'h1, 32'h1F, mkInstr(7'b0110011, 3'b001, 12'h000), 1'b0, 32'h80000000);
    applyCheck("R6", 32'hFFFFFFFF, 32'h1, mkInstr(7'b0110011, 3'b010, 12'h000), 1'b0, 32'h1);
    applyCheck("R6", 32'h1, 32'h80000000, mkInstr(7'b0110011, 3'b010, 12'h000), 1'b0, 32'h0);
    applyCheck("R6", 32'h5, 32'h5, mkInstr(7'b0110011, 3'b010, 12'h000), 1'b0, 32'h0);
    applyCheck("R8", 32'hDEADBEEF, 32'h55, {20'h12345, 5'd3, 7'b0110111}, 1'b1, 32'h12345000);
    applyCheck("R9", 32'h7, 32'h9, mkInstr(7'b0000011, 3'b000, 12'h000), 1'b0, 32'h0);
    applyCheck("R9", 32'h7, 32'h9, mkInstr(7'b0110011, 3'b011, 12'h000), 1'b0, 32'h0);
    applyCheck("R10", 32'h7, 32'h9, mkInstr(7'b0010011, 3'b110, 12'h800), 1'b0, 32'hF);

    // Full decode sweep against the arithmetic model (R1..R10)
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        for (int o = 0; o < 4; o++) begin
          for (int f = 0; f < 8; f++) begin
            for (int s = 0; s < 4; s++) begin
              logic [11:0] immv;
              logic [31:0] ins;
              immv     = imms[(i + j + f) % 8];
              immv[10] = s[0];
              ins      = mkInstr(opcs[o], f[2:0], immv);
              applyCheck(s[1] ? "R7" : tagOf(ins), opnd[i], opnd[j], ins, s[1],
                         refModel(opnd[i], opnd[j], ins, s[1]));
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule